// File: doc/BRIEF.md
# Direct-Page Effective Address Generator

This block forms the data-memory address used by an 8-bit controller core for four of its addressing modes. Each cycle in which the core raises a request, the block decodes the fetched opcode together with up to two operand bytes, the X index register, the page-select flag and the page register. One clock later it presents a 16-bit address with a valid strobe. If the opcode is not one of the four it handles, it raises an illegal flag instead.

Modes that address the direct page build the upper address byte from the page selection. When the flag is clear, that byte is 00H. When the flag is set, it is the page register. The lower byte always wraps within the page. Absolute addressing takes the 16-bit operand as it stands. The post-increment mode also returns X+1 with a one-cycle write-enable so that the core can update its index register.

Top module: `dp_ea_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ea`, `x_next` and all strobes (`ea_valid`, `illegal_op`, `x_wr`) are zero.
- R2: Opcode 98H (absolute) yields `ea` = {`opnd1`, `opnd0`}: operand byte 1 is the high byte and operand byte 0 is the low byte. Neither `pg_sel` nor `pg_reg` affects the result.
- R3: In the direct-page modes (D4H, DBH, C6H), the high byte of `ea` is 00H when `pg_sel`=0 and `pg_reg` when `pg_sel`=1.
- R4: Opcode D4H (X-indirect) yields `ea` low byte = `x_in`.
- R5: Opcode DBH (X-indirect, post-increment) yields `ea` low byte = `x_in`, `x_next` = (`x_in`+1) mod 256 (FFH wraps to 00H), and `x_wr`=1.
- R6: Opcode C6H (direct page plus X) yields `ea` low byte = (`opnd0`+`x_in`) mod 256. The carry is dropped and never changes the high byte.
- R7: `ea_valid` is high in exactly the cycle after a cycle with `req`=1 and a recognised opcode. In cycles after `req`=0, all strobes are low and `ea` and `x_next` keep their values.
- R8: Any opcode other than 98H, D4H, DBH and C6H, when requested, raises `illegal_op` for one cycle with `ea_valid`=0 and `x_wr`=0, and leaves `ea` and `x_next` unchanged.
- R9: `x_wr` is asserted only in the cycle after a DBH request, for one cycle, and `x_next` changes only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Decode request, sampled on the rising edge |
| opcode | input | 8 | Fetched opcode byte |
| opnd0 | input | 8 | First operand byte (offset, or absolute low byte) |
| opnd1 | input | 8 | Second operand byte (absolute high byte) |
| x_in | input | 8 | Current X index register |
| pg_sel | input | 1 | Page-select flag: 0 selects page 0, 1 selects `pg_reg` |
| pg_reg | input | 8 | Direct-page register |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | Address valid strobe |
| illegal_op | output | 1 | Unrecognised opcode strobe |
| x_next | output | 8 | Post-incremented X value |
| x_wr | output | 1 | Write-enable for `x_next` |

## Verification
The bench builds the block with its default byte width of 8 and address width of 16. At these widths the opcode byte and the X register are each small enough to sweep over all 256 values. Every opcode is requested once, so each unknown code gets its own illegal check. The post-increment and offset-plus-X modes are then swept over every X value with both page selections, which covers the FFH-to-00H wrap and every carry case of the in-page sum. Further sweeps run the page register through all its values for the X-indirect and absolute modes, and idle cycles between requests show that the strobes fall and the outputs hold.

// File: rtl/dp_ea_pkg.sv
package dp_ea_pkg;
   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_ABS  = 8'h98;
   localparam logic [BYTE_W-1:0] OP_XIND = 8'hD4;
   localparam logic [BYTE_W-1:0] OP_XINC = 8'hDB;
   localparam logic [BYTE_W-1:0] OP_DPX  = 8'hC6;

   typedef enum logic [2:0] {
      AM_ABS  = 3'd0,
      AM_XIND = 3'd1,
      AM_XINC = 3'd2,
      AM_DPX  = 3'd3,
      AM_BAD  = 3'd4
   } amode_t;
endpackage

// File: rtl/dp_ea_decode.sv
module dp_ea_decode
   import dp_ea_pkg::*;
#(
   parameter int OPC_W = 8
) (
   input  logic [OPC_W-1:0] opcode,
   output amode_t           mode
);
   generate
      if (OPC_W != BYTE_W) begin : g_bad_w
         $error("dp_ea_decode: opcode width must be %0d", BYTE_W);
      end
   endgenerate

   always_comb begin
      unique case (opcode)
         OP_ABS:  mode = AM_ABS;
         OP_XIND: mode = AM_XIND;
         OP_XINC: mode = AM_XINC;
         OP_DPX:  mode = AM_DPX;
         default: mode = AM_BAD;
      endcase
   end
endmodule

// File: rtl/dp_ea_form.sv
module dp_ea_form
   import dp_ea_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  amode_t          mode,
   input  logic [DW-1:0]   opnd0,
   input  logic [DW-1:0]   opnd1,
   input  logic [DW-1:0]   x_in,
   input  logic            pg_sel,
   input  logic [DW-1:0]   pg_reg,
   output logic [AW-1:0]   ea_comb
);
   localparam int HI_W = AW - DW;

   generate
      if (HI_W != DW) begin : g_bad_aw
         $error("dp_ea_form: address width must be twice the byte width");
      end
   endgenerate

   logic [DW-1:0] page_hi;
   logic [DW-1:0] off_sum;

   assign page_hi = pg_sel ? pg_reg : '0;
   assign off_sum = opnd0 + x_in;

   always_comb begin
      case (mode)
         AM_ABS:          ea_comb = {opnd1, opnd0};
         AM_XIND,
         AM_XINC:         ea_comb = {page_hi, x_in};
         AM_DPX:          ea_comb = {page_hi, off_sum};
         default:         ea_comb = '0;
      endcase
   end
endmodule

// File: rtl/dp_ea_xupd.sv
module dp_ea_xupd #(
   parameter int DW = 8
) (
   input  logic [DW-1:0] x_in,
   output logic [DW-1:0] x_inc
);
   generate
      if (DW < 1) begin : g_bad_dw
         $error("dp_ea_xupd: width must be positive");
      end
   endgenerate

   assign x_inc = x_in + DW'(1);
endmodule

// File: rtl/dp_ea_gen.sv
module dp_ea_gen
   import dp_ea_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] opcode,
   input  logic [DW-1:0] opnd0,
   input  logic [DW-1:0] opnd1,
   input  logic [DW-1:0] x_in,
   input  logic          pg_sel,
   input  logic [DW-1:0] pg_reg,
   output logic [AW-1:0] ea,
   output logic          ea_valid,
   output logic          illegal_op,
   output logic [DW-1:0] x_next,
   output logic          x_wr
);
   generate
      if (AW != 2 * DW) begin : g_bad_cfg
         $error("dp_ea_gen: AW must equal 2*DW");
      end
   endgenerate

   amode_t        mode;
   logic [AW-1:0] ea_comb;
   logic [DW-1:0] x_inc;
   logic          known;

   dp_ea_decode #(.OPC_W(DW)) u_dec (
      .opcode (opcode),
      .mode   (mode)
   );

   dp_ea_form #(.DW(DW), .AW(AW)) u_form (
      .mode    (mode),
      .opnd0   (opnd0),
      .opnd1   (opnd1),
      .x_in    (x_in),
      .pg_sel  (pg_sel),
      .pg_reg  (pg_reg),
      .ea_comb (ea_comb)
   );

   dp_ea_xupd #(.DW(DW)) u_xupd (
      .x_in  (x_in),
      .x_inc (x_inc)
   );

   assign known = (mode != AM_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea         <= '0;
         ea_valid   <= 1'b0;
         illegal_op <= 1'b0;
         x_next     <= '0;
         x_wr       <= 1'b0;
      end else begin
         ea_valid   <= req && known;
         illegal_op <= req && !known;
         x_wr       <= req && (mode == AM_XINC);
         if (req && known) begin
            ea <= ea_comb;
         end
         if (req && (mode == AM_XINC)) begin
            x_next <= x_inc;
         end
      end
   end
endmodule

// File: rtl/dp_ea_gen_chk.sv
module dp_ea_gen_chk #(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic [DW-1:0] opcode,
   input  logic [DW-1:0] opnd0,
   input  logic [DW-1:0] opnd1,
   input  logic [DW-1:0] x_in,
   input  logic [AW-1:0] ea,
   input  logic          ea_valid,
   input  logic          illegal_op,
   input  logic [DW-1:0] x_next,
   input  logic          x_wr
);
   // R8: valid and illegal are exclusive
   assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ea_valid && illegal_op));

   // R9: write-enable only alongside a valid DBH result
   assert_xwr_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      x_wr |-> ea_valid);

   // R5: written-back X is the sampled X plus one
   assert_xinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && opcode == 8'hDB) |=> (x_wr && x_next == DW'($past(x_in) + DW'(1))));

   // R2: absolute mode passes the operand through
   assert_abs_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req && opcode == 8'h98) |=> (ea_valid && ea == {$past(opnd1), $past(opnd0)}));

   // R7: no strobes without a request, and outputs hold
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!ea_valid && !illegal_op && !x_wr && $stable(ea) && $stable(x_next)));
endmodule

bind dp_ea_gen dp_ea_gen_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req        (req),
   .opcode     (opcode),
   .opnd0      (opnd0),
   .opnd1      (opnd1),
   .x_in       (x_in),
   .ea         (ea),
   .ea_valid   (ea_valid),
   .illegal_op (illegal_op),
   .x_next     (x_next),
   .x_wr       (x_wr)
);

// File: tb/sim_dp_ea_gen.sv
module sim_dp_ea_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [7:0]  opcode = '0, opnd0 = '0, opnd1 = '0, x_in = '0, pg_reg = '0;
   logic        pg_sel = 1'b0;
   logic [15:0] ea;
   logic        ea_valid, illegal_op, x_wr;
   logic [7:0]  x_next;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   logic [15:0] m_ea = '0;
   logic [7:0]  m_x  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_ea_gen u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .opcode(opcode), .opnd0(opnd0),
      .opnd1(opnd1), .x_in(x_in), .pg_sel(pg_sel), .pg_reg(pg_reg),
      .ea(ea), .ea_valid(ea_valid), .illegal_op(illegal_op),
      .x_next(x_next), .x_wr(x_wr)
   );

   task automatic cmp(string tag, logic [15:0] e_ea, logic e_v, logic e_il,
                      logic [7:0] e_x, logic e_w);
      n_vec++;
      if (ea !== e_ea || ea_valid !== e_v || illegal_op !== e_il ||
          x_next !== e_x || x_wr !== e_w) begin
         n_bad++;
         $display("FAIL %s: got ea=%h v=%b il=%b x=%h w=%b exp ea=%h v=%b il=%b x=%h w=%b",
                  tag, ea, ea_valid, illegal_op, x_next, x_wr,
                  e_ea, e_v, e_il, e_x, e_w);
      end
   endtask

   // apply one request, check the registered result, then one idle cycle (R7)
   task automatic apply(logic [7:0] op, logic [7:0] b0, logic [7:0] b1,
                        logic [7:0] x, logic g, logic [7:0] pg);
      logic [7:0] hi;
      string tag;
      logic v, il, w;
      hi = g ? pg : 8'h00;
      v = 1'b1; il = 1'b0; w = 1'b0;
      case (op)
         8'h98: begin m_ea = {b1, b0}; tag = "R2"; end
         8'hD4: begin m_ea = {hi, x}; tag = "R4/R3"; end
         8'hDB: begin m_ea = {hi, x}; m_x = x + 8'd1; w = 1'b1; tag = "R5/R9"; end
         8'hC6: begin m_ea = {hi, 8'(b0 + x)}; tag = "R6/R3"; end
         default: begin v = 1'b0; il = 1'b1; tag = "R8"; end
      endcase
      @(negedge clk);
      req = 1'b1; opcode = op; opnd0 = b0; opnd1 = b1; x_in = x;
      pg_sel = g; pg_reg = pg;
      @(negedge clk);
      req = 1'b0;
      opnd0 = ~b0; opnd1 = ~b1; x_in = ~x; pg_reg = ~pg;
      cmp(tag, m_ea, v, il, m_x, w);
      @(negedge clk);
      cmp("R7", m_ea, 1'b0, 1'b0, m_x, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1", 16'h0, 1'b0, 1'b0, 8'h00, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1", 16'h0, 1'b0, 1'b0, 8'h00, 1'b0);
      // every opcode
      for (int i = 0; i < 256; i++)
         apply(8'(i), 8'(i * 3), ~8'(i), 8'(i) ^ 8'h5A, i[0], 8'hC3);
      // post-increment and offset-plus-X over every X, both pages
      for (int g = 0; g < 2; g++)
         for (int x = 0; x < 256; x++) begin
            apply(8'hDB, 8'h11, 8'h22, 8'(x), g[0], 8'h7E);
            apply(8'hC6, 8'h45, 8'h99, 8'(x), g[0], 8'hA5);
         end
      // X-indirect and absolute over every page register value
      for (int p = 0; p < 256; p++) begin
         apply(8'hD4, 8'h00, 8'h00, 8'h15, 1'b1, 8'(p));
         apply(8'h98, 8'h35, 8'(p), 8'hF0, p[0], ~8'(p));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule